// File: doc/BRIEF.md
# ATA Command and PIO Transfer Sequencer

This block sits behind the task-file registers of one disk channel. It takes command bytes, a sector-count register write and data-port accesses of 1, 2 or 4 bytes. From these it sequences the busy, ready, data-request, error and seek-complete status bits and a one-cycle interrupt pulse. It keeps a transfer index, a transfer length and a current LBA. A local byte buffer holds the data that the host reads or writes through the data port.

Backing storage and packet interpretation are outside the block. When the block needs buffer contents, it raises a fill request that carries a kind and an LBA. The storage side then writes 32-bit words straight into the buffer and ends the request with a one-cycle acknowledge. Three events raise a fill request: an identify command, a sector-read command, and the last byte of a 12-byte command packet. A read that crosses into a new block also raises one, and in that case the LBA advances first.

Top module: `ata_pio_seq`

## Requirements
- R1: After reset, status is 0x50, the error register is 0x01, sector count is 1, and neither the fill request nor the interrupt is active. Status bits: 7 busy, 6 ready, 5 write fault, 4 seek complete, 3 data request, 0 error. Error-register bit 2 is abort.
- R2: A command is accepted as an identify in two cases: 0xEC on a disk slot (slotKind 1), and 0xA1 on a packet slot (slotKind 2). Acceptance raises a fill request of kind 0 and shows status 0x80 while the request is pending. On acknowledge, the error register becomes 0, status becomes 0x58, a 512-byte transfer is armed at index 0, and an interrupt pulse is given.
- R3: Some commands do not match the selected slot. These are 0xEC on a slot that is not a disk; 0xA1 or 0xA0 on a slot that is not a packet slot; and 0x20, 0x21 or 0x24 on a slot that is not a disk. Each of these sets status to 0x41 and the error register to 0x04, pulses the interrupt and raises no fill request.
- R4: 0xA0 on a packet slot does the following: sets sector count to 1; clears busy, write fault and error; sets data request; arms a 12-byte write transfer at index 0. It raises no interrupt.
- R5: A data write stores its bytes little-endian at the transfer index. dataSize 0, 1 and 2 mean 1, 2 and 4 bytes. The index then advances by that length. Under 0xA0, the write that brings the index to the length raises a fill request of kind 2. On acknowledge, the length becomes fillLen and the index becomes 0. Status becomes 0x58 (0x50 if fillLen is 0) and an interrupt is pulsed.
- R6: 0x20, 0x21 or 0x24 on a disk slot does the following: loads the current LBA from lbaIn; arms a transfer of sector count × 512 bytes at index 0; raises a fill request of kind 1 at lbaIn. On acknowledge, status becomes 0x58 and an interrupt is pulsed.
- R7: A data read on a disk or packet slot returns the buffer at the index modulo the block size, with rdValid, one cycle after the strobe. The block size is 512 for a disk and 2048 for a packet slot. Bytes beyond the access length read as zero.
- R8: A read that starts on a block boundary with a nonzero index first increments the current LBA. It then raises a fill request of kind 1 at the new LBA, with busy set. The data is returned, from offset 0, one cycle after the acknowledge.
- R9: A read can leave the index on a block boundary. In that case data request stays set if the index is below the length and clears otherwise. Ready is set, busy is cleared, and an interrupt pulses together with rdValid. Other reads give no interrupt.
- R10: A read with the index at or beyond the length is an overrun. It returns zero, sets the status error bit, and leaves the index unchanged.
- R11: While the last command is an identify, a read shows busy 0, ready 1, write fault 0, seek complete 1 and error 0. Data request clears once 512 bytes have been read, and no interrupt is given.
- R12: 0xEF clears busy, write fault and error, sets ready and seek complete, and pulses the interrupt.
- R13: Any other command code sets the status error bit and the error-register abort bit without an interrupt. A data read on an empty slot (slotKind 0) returns zero with rdValid.
- R14: While a fill request is pending, command, sector-count and data-port strobes are ignored. The request and its LBA are held until the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrEn | input | 1 | Command register write strobe |
| cmdData | input | 8 | Command code |
| secCntWrEn | input | 1 | Sector count register write strobe |
| secCntData | input | 8 | Sector count value |
| lbaIn | input | LBA_W | Starting LBA for sector reads |
| slotKind | input | 2 | Selected slot: 0 empty, 1 disk, 2 packet device |
| dataWrEn | input | 1 | Data port write strobe |
| dataRdEn | input | 1 | Data port read strobe |
| dataSize | input | 2 | Access length code: 0 one byte, 1 two, 2 four |
| dataWrData | input | 32 | Data port write value, little-endian |
| rdData | output | 32 | Data port read value |
| rdValid | output | 1 | rdData valid pulse |
| status | output | 8 | Status register |
| errReg | output | 8 | Error register |
| secCount | output | 8 | Sector count register |
| irq | output | 1 | Interrupt request pulse |
| fillReq | output | 1 | Buffer fill request |
| fillKind | output | 2 | Fill kind: 0 identify, 1 sector, 2 packet |
| fillLba | output | LBA_W | LBA for a sector fill |
| fillLen | input | IDX_W | Response length for a packet fill |
| fillWe | input | 1 | Buffer word write strobe from storage |
| fillAddr | input | WORD_AW | Buffer word address |
| fillData | input | 32 | Buffer word, little-endian |
| fillAck | input | 1 | Fill complete pulse |

## Verification
Command results are due one cycle after a command strobe: status, the error register, sector count, the interrupt pulse and the fill request all appear on that edge. A fill that is acknowledged shows its final status and interrupt one cycle after the acknowledge. A data read returns rdValid and data one cycle after the strobe; when the read triggers a refill, they come one cycle after the acknowledge instead. The bench drives every strobe for exactly one cycle and samples on the following falling edge. For reads and fills it waits on rdValid or the interrupt pulse, and then checks both the value and the number of cycles it waited.

// File: rtl/ata_seq_pkg.sv
`timescale 1ns/1ps
package ata_seq_pkg;

  localparam logic [1:0] SLOT_NONE = 2'd0;
  localparam logic [1:0] SLOT_DISK = 2'd1;
  localparam logic [1:0] SLOT_PKT  = 2'd2;

  localparam logic [1:0] FK_IDENT  = 2'd0;
  localparam logic [1:0] FK_SECTOR = 2'd1;
  localparam logic [1:0] FK_PACKET = 2'd2;

  localparam logic [7:0] CMD_IDENT     = 8'hEC;
  localparam logic [7:0] CMD_PKT_IDENT = 8'hA1;
  localparam logic [7:0] CMD_PACKET    = 8'hA0;
  localparam logic [7:0] CMD_RD_RETRY  = 8'h20;
  localparam logic [7:0] CMD_RD_NORTRY = 8'h21;
  localparam logic [7:0] CMD_RD_EXT    = 8'h24;
  localparam logic [7:0] CMD_FEATURES  = 8'hEF;

  localparam int ST_BUSY = 7;
  localparam int ST_RDY  = 6;
  localparam int ST_SEEK = 4;
  localparam int ST_DRQ  = 3;
  localparam int ST_ERR  = 0;
  localparam int ER_ABRT = 2;

  typedef enum logic [1:0] {S_IDLE, S_FILL_CMD, S_FILL_RD} seq_state_t;

  typedef struct packed {
    logic hostWr;
    logic rdCapture;
    logic rdZero;
  } dp_strobe_t;

  function automatic logic [2:0] sizeLen(input logic [1:0] code);
    case (code)
      2'd0:    sizeLen = 3'd1;
      2'd1:    sizeLen = 3'd2;
      default: sizeLen = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/ata_seq_dpath.sv
`timescale 1ns/1ps
module ata_seq_dpath
  import ata_seq_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  localparam int OFF_W   = $clog2(BUF_BYTES),
  localparam int WORD_AW = OFF_W - 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  dp_strobe_t         strobe,
  input  logic [OFF_W-1:0]   offset,
  input  logic [1:0]         accSize,
  input  logic [31:0]        wrData,
  input  logic               fillWe,
  input  logic [WORD_AW-1:0] fillAddr,
  input  logic [31:0]        fillData,
  output logic [31:0]        rdData
);

  logic [7:0] bufMem [BUF_BYTES];
  logic [2:0] accLen;

  assign accLen = sizeLen(accSize);

  always_ff @(posedge clk) begin
    if (strobe.hostWr) begin
      for (int b = 0; b < 4; b++) begin
        if (3'(b) < accLen) bufMem[offset + OFF_W'(b)] <= wrData[8*b +: 8];
      end
    end
    if (fillWe) begin
      for (int b = 0; b < 4; b++) begin
        bufMem[{fillAddr, 2'(b)}] <= fillData[8*b +: 8];
      end
    end
  end

  logic [31:0] readWord;
  genvar lane;
  generate
    for (lane = 0; lane < 4; lane++) begin : g_lane
      assign readWord[8*lane +: 8] = (3'(lane) < accLen) ?
                                     bufMem[offset + OFF_W'(lane)] : 8'h00;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobe.rdZero) begin
      rdData <= '0;
    end else if (strobe.rdCapture) begin
      rdData <= readWord;
    end
  end

endmodule

// File: rtl/ata_seq_ctrl.sv
`timescale 1ns/1ps
module ata_seq_ctrl
  import ata_seq_pkg::*;
#(
  parameter int BUF_BYTES  = 2048,
  parameter int SECT_BYTES = 512,
  parameter int PKT_BYTES  = 12,
  parameter int LBA_W      = 32,
  localparam int OFF_W = $clog2(BUF_BYTES),
  localparam int IDX_W = $clog2(SECT_BYTES * 256) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWrEn,
  input  logic [7:0]       cmdData,
  input  logic             secCntWrEn,
  input  logic [7:0]       secCntData,
  input  logic [LBA_W-1:0] lbaIn,
  input  logic [1:0]       slotKind,
  input  logic             dataWrEn,
  input  logic             dataRdEn,
  input  logic [1:0]       dataSize,
  input  logic             fillAck,
  input  logic [IDX_W-1:0] fillLen,
  output dp_strobe_t       strobe,
  output logic [OFF_W-1:0] bufOffset,
  output logic [1:0]       accSize,
  output logic [7:0]       status,
  output logic [7:0]       errReg,
  output logic [7:0]       secCount,
  output logic             irq,
  output logic             rdValid,
  output logic             fillReq,
  output logic [1:0]       fillKind,
  output logic [LBA_W-1:0] fillLba
);

  localparam logic [IDX_W-1:0] SECT_MASK = IDX_W'(SECT_BYTES - 1);
  localparam logic [IDX_W-1:0] BUF_MASK  = IDX_W'(BUF_BYTES - 1);

  seq_state_t       state, stateN;
  logic [7:0]       cmdReg, cmdRegN;
  logic [7:0]       statusN, errRegN, secCountN;
  logic [IDX_W-1:0] idx, idxN, xferLen, xferLenN;
  logic [LBA_W-1:0] curLba, curLbaN, fillLbaN;
  logic [1:0]       kindN, pendSize, pendSizeN;
  logic             irqN, rdValidN;

  logic             doComplete;
  logic [1:0]       compSize;
  logic [IDX_W-1:0] accLen, compLen, blockMask, blockOff, nextIdx;
  logic             diskSlot, pktSlot, identActive;

  assign diskSlot    = (slotKind == SLOT_DISK);
  assign pktSlot     = (slotKind == SLOT_PKT);
  assign identActive = (cmdReg == CMD_IDENT) || (cmdReg == CMD_PKT_IDENT);
  assign accLen      = IDX_W'(sizeLen(dataSize));
  assign blockMask   = diskSlot ? SECT_MASK : BUF_MASK;
  assign blockOff    = idx & blockMask;
  assign compLen     = IDX_W'(sizeLen(compSize));
  assign nextIdx     = idx + compLen;

  always_comb begin
    stateN     = state;
    cmdRegN    = cmdReg;
    statusN    = status;
    errRegN    = errReg;
    secCountN  = secCount;
    idxN       = idx;
    xferLenN   = xferLen;
    curLbaN    = curLba;
    fillLbaN   = fillLba;
    kindN      = fillKind;
    pendSizeN  = pendSize;
    irqN       = 1'b0;
    rdValidN   = 1'b0;
    strobe     = '0;
    bufOffset  = idx[OFF_W-1:0];
    doComplete = 1'b0;
    compSize   = dataSize;

    case (state)
      S_IDLE: begin
        if (cmdWrEn) begin
          cmdRegN = cmdData;
          case (cmdData)
            CMD_IDENT, CMD_PKT_IDENT: begin
              if ((cmdData == CMD_IDENT && diskSlot) ||
                  (cmdData == CMD_PKT_IDENT && pktSlot)) begin
                stateN  = S_FILL_CMD;
                kindN   = FK_IDENT;
                statusN = 8'h80;
              end else begin
                statusN = 8'h41;
                errRegN = 8'h04;
                irqN    = 1'b1;
              end
            end
            CMD_PACKET: begin
              if (pktSlot) begin
                secCountN = 8'd1;
                statusN   = (status & ~8'hA1) | 8'h08;
                xferLenN  = IDX_W'(PKT_BYTES);
                idxN      = '0;
              end else begin
                statusN = 8'h41;
                errRegN = 8'h04;
                irqN    = 1'b1;
              end
            end
            CMD_RD_RETRY, CMD_RD_NORTRY, CMD_RD_EXT: begin
              if (diskSlot) begin
                curLbaN  = lbaIn;
                fillLbaN = lbaIn;
                xferLenN = IDX_W'(secCount) * IDX_W'(SECT_BYTES);
                idxN     = '0;
                kindN    = FK_SECTOR;
                stateN   = S_FILL_CMD;
                statusN  = 8'h80;
              end else begin
                statusN = 8'h41;
                errRegN = 8'h04;
                irqN    = 1'b1;
              end
            end
            CMD_FEATURES: begin
              statusN = (status & ~8'hA1) | 8'h50;
              irqN    = 1'b1;
            end
            default: begin
              statusN[ST_ERR]  = 1'b1;
              errRegN[ER_ABRT] = 1'b1;
            end
          endcase
        end else if (secCntWrEn) begin
          secCountN = secCntData;
        end else if (dataWrEn) begin
          strobe.hostWr = 1'b1;
          idxN          = idx + accLen;
          if (cmdReg == CMD_PACKET && xferLen != '0 && (idx + accLen) >= xferLen) begin
            stateN  = S_FILL_CMD;
            kindN   = FK_PACKET;
            statusN = 8'h80;
          end
        end else if (dataRdEn) begin
          if (identActive) begin
            strobe.rdCapture = 1'b1;
            rdValidN         = 1'b1;
            idxN             = idx + accLen;
            statusN          = (status & ~8'hA5) | 8'h50;
            if ((idx + accLen) >= xferLen) statusN[ST_DRQ] = 1'b0;
          end else if (!diskSlot && !pktSlot) begin
            strobe.rdZero = 1'b1;
            rdValidN      = 1'b1;
          end else if (idx >= xferLen) begin
            strobe.rdZero   = 1'b1;
            rdValidN        = 1'b1;
            statusN[ST_ERR] = 1'b1;
          end else if (blockOff == '0 && idx != '0) begin
            curLbaN          = curLba + 1'b1;
            fillLbaN         = curLba + 1'b1;
            kindN            = FK_SECTOR;
            pendSizeN        = dataSize;
            stateN           = S_FILL_RD;
            statusN[ST_BUSY] = 1'b1;
          end else begin
            doComplete = 1'b1;
          end
        end
      end

      S_FILL_CMD: begin
        if (fillAck) begin
          stateN = S_IDLE;
          irqN   = 1'b1;
          case (fillKind)
            FK_IDENT: begin
              errRegN  = 8'h00;
              statusN  = 8'h58;
              idxN     = '0;
              xferLenN = IDX_W'(SECT_BYTES);
            end
            FK_PACKET: begin
              xferLenN = fillLen;
              idxN     = '0;
              statusN  = (fillLen != '0) ? 8'h58 : 8'h50;
            end
            default: statusN = 8'h58;
          endcase
        end
      end

      S_FILL_RD: begin
        if (fillAck) begin
          stateN     = S_IDLE;
          compSize   = pendSize;
          doComplete = 1'b1;
        end
      end

      default: stateN = S_IDLE;
    endcase

    if (doComplete) begin
      strobe.rdCapture = 1'b1;
      bufOffset        = blockOff[OFF_W-1:0];
      rdValidN         = 1'b1;
      idxN             = nextIdx;
      statusN[ST_BUSY] = 1'b0;
      if ((nextIdx & blockMask) == '0) begin
        statusN[ST_DRQ] = (nextIdx < xferLen);
        statusN[ST_RDY] = 1'b1;
        irqN            = 1'b1;
      end
    end
  end

  assign accSize = (state == S_FILL_RD) ? pendSize : dataSize;
  assign fillReq = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      cmdReg   <= 8'h00;
      status   <= 8'h50;
      errReg   <= 8'h01;
      secCount <= 8'h01;
      idx      <= '0;
      xferLen  <= '0;
      curLba   <= '0;
      fillLba  <= '0;
      fillKind <= FK_IDENT;
      pendSize <= 2'd0;
      irq      <= 1'b0;
      rdValid  <= 1'b0;
    end else begin
      state    <= stateN;
      cmdReg   <= cmdRegN;
      status   <= statusN;
      errReg   <= errRegN;
      secCount <= secCountN;
      idx      <= idxN;
      xferLen  <= xferLenN;
      curLba   <= curLbaN;
      fillLba  <= fillLbaN;
      fillKind <= kindN;
      pendSize <= pendSizeN;
      irq      <= irqN;
      rdValid  <= rdValidN;
    end
  end

endmodule

// File: rtl/ata_pio_seq.sv
`timescale 1ns/1ps
module ata_pio_seq
  import ata_seq_pkg::*;
#(
  parameter int BUF_BYTES  = 2048,
  parameter int SECT_BYTES = 512,
  parameter int PKT_BYTES  = 12,
  parameter int LBA_W      = 32,
  localparam int OFF_W   = $clog2(BUF_BYTES),
  localparam int WORD_AW = OFF_W - 2,
  localparam int IDX_W   = $clog2(SECT_BYTES * 256) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdWrEn,
  input  logic [7:0]         cmdData,
  input  logic               secCntWrEn,
  input  logic [7:0]         secCntData,
  input  logic [LBA_W-1:0]   lbaIn,
  input  logic [1:0]         slotKind,
  input  logic               dataWrEn,
  input  logic               dataRdEn,
  input  logic [1:0]         dataSize,
  input  logic [31:0]        dataWrData,
  output logic [31:0]        rdData,
  output logic               rdValid,
  output logic [7:0]         status,
  output logic [7:0]         errReg,
  output logic [7:0]         secCount,
  output logic               irq,
  output logic               fillReq,
  output logic [1:0]         fillKind,
  output logic [LBA_W-1:0]   fillLba,
  input  logic [IDX_W-1:0]   fillLen,
  input  logic               fillWe,
  input  logic [WORD_AW-1:0] fillAddr,
  input  logic [31:0]        fillData,
  input  logic               fillAck
);

  dp_strobe_t       dpStrobe;
  logic [OFF_W-1:0] bufOffset;
  logic [1:0]       accSize;

  ata_seq_ctrl #(
    .BUF_BYTES(BUF_BYTES), .SECT_BYTES(SECT_BYTES),
    .PKT_BYTES(PKT_BYTES), .LBA_W(LBA_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .cmdWrEn(cmdWrEn), .cmdData(cmdData),
    .secCntWrEn(secCntWrEn), .secCntData(secCntData),
    .lbaIn(lbaIn), .slotKind(slotKind),
    .dataWrEn(dataWrEn), .dataRdEn(dataRdEn), .dataSize(dataSize),
    .fillAck(fillAck), .fillLen(fillLen),
    .strobe(dpStrobe), .bufOffset(bufOffset), .accSize(accSize),
    .status(status), .errReg(errReg), .secCount(secCount),
    .irq(irq), .rdValid(rdValid),
    .fillReq(fillReq), .fillKind(fillKind), .fillLba(fillLba)
  );

  ata_seq_dpath #(.BUF_BYTES(BUF_BYTES)) uDpath (
    .clk(clk), .rstN(rstN),
    .strobe(dpStrobe), .offset(bufOffset), .accSize(accSize),
    .wrData(dataWrData),
    .fillWe(fillWe), .fillAddr(fillAddr), .fillData(fillData),
    .rdData(rdData)
  );

endmodule

// File: rtl/ata_pio_seq_chk.sv
`timescale 1ns/1ps
module ata_pio_seq_chk #(
  parameter int LBA_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdWrEn,
  input logic [7:0]       cmdData,
  input logic [1:0]       slotKind,
  input logic [7:0]       status,
  input logic [7:0]       errReg,
  input logic [7:0]       secCount,
  input logic             irq,
  input logic             rdValid,
  input logic             fillReq,
  input logic             fillAck,
  input logic [LBA_W-1:0] fillLba
);

  logic knownCmd;
  assign knownCmd = (cmdData == 8'hEC) || (cmdData == 8'hA1) || (cmdData == 8'hA0) ||
                    (cmdData == 8'h20) || (cmdData == 8'h21) || (cmdData == 8'h24) ||
                    (cmdData == 8'hEF);

  a_r14_req_held: assert property (@(posedge clk) disable iff (!rstN)
    fillReq && !fillAck |=> fillReq && $stable(fillLba));

  a_r2_busy_pending: assert property (@(posedge clk) disable iff (!rstN)
    fillReq |-> status[7]);

  a_r3_abort: assert property (@(posedge clk) disable iff (!rstN)
    !fillReq && cmdWrEn && cmdData == 8'hEC && slotKind != 2'd1
    |=> status == 8'h41 && errReg == 8'h04 && irq && !fillReq);

  a_r4_packet_arm: assert property (@(posedge clk) disable iff (!rstN)
    !fillReq && cmdWrEn && cmdData == 8'hA0 && slotKind == 2'd2
    |=> status[3] && !status[7] && !status[0] && !irq && secCount == 8'd1 && !fillReq);

  a_r12_features: assert property (@(posedge clk) disable iff (!rstN)
    !fillReq && cmdWrEn && cmdData == 8'hEF
    |=> irq && status[6] && status[4] && !status[7] && !status[0]);

  a_r13_unknown: assert property (@(posedge clk) disable iff (!rstN)
    !fillReq && cmdWrEn && !knownCmd |=> !irq && status[0] && errReg[2]);

  a_r7_valid_idle: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !fillReq);

endmodule

bind ata_pio_seq ata_pio_seq_chk #(.LBA_W(LBA_W)) uChk (
  .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdData(cmdData),
  .slotKind(slotKind), .status(status), .errReg(errReg), .secCount(secCount),
  .irq(irq), .rdValid(rdValid), .fillReq(fillReq), .fillAck(fillAck),
  .fillLba(fillLba)
);

// File: tb/ata_pio_seq_test.sv
`timescale 1ns/1ps
module ata_pio_seq_test;

  localparam int LBA_W = 32;
  localparam int IDX_W = 18;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cmdWrEn = 1'b0;
  logic [7:0]       cmdData = '0;
  logic             secCntWrEn = 1'b0;
  logic [7:0]       secCntData = '0;
  logic [LBA_W-1:0] lbaIn = '0;
  logic [1:0]       slotKind = '0;
  logic             dataWrEn = 1'b0;
  logic             dataRdEn = 1'b0;
  logic [1:0]       dataSize = '0;
  logic [31:0]      dataWrData = '0;
  logic [31:0]      rdData;
  logic             rdValid;
  logic [7:0]       status, errReg, secCount;
  logic             irq, fillReq;
  logic [1:0]       fillKind;
  logic [LBA_W-1:0] fillLba;
  logic [IDX_W-1:0] fillLen = '0;
  logic             fillWe = 1'b0;
  logic [8:0]       fillAddr = '0;
  logic [31:0]      fillData = '0;
  logic             fillAck = 1'b0;

  int checks = 0;
  int fails = 0;
  int fillCount = 0;
  int rdValidCount = 0;
  logic [1:0]       lastKind = '0;
  logic [LBA_W-1:0] lastLba = '0;

  always #2.5 clk = ~clk;

  ata_pio_seq uut (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdData(cmdData),
    .secCntWrEn(secCntWrEn), .secCntData(secCntData), .lbaIn(lbaIn),
    .slotKind(slotKind), .dataWrEn(dataWrEn), .dataRdEn(dataRdEn),
    .dataSize(dataSize), .dataWrData(dataWrData), .rdData(rdData),
    .rdValid(rdValid), .status(status), .errReg(errReg), .secCount(secCount),
    .irq(irq), .fillReq(fillReq), .fillKind(fillKind), .fillLba(fillLba),
    .fillLen(fillLen), .fillWe(fillWe), .fillAddr(fillAddr),
    .fillData(fillData), .fillAck(fillAck)
  );

  function automatic logic [7:0] expByte(input logic [1:0] kind, input logic [31:0] lba,
                                         input int addr);
    case (kind)
      2'd0:    expByte = 8'(addr) ^ 8'h5A;
      2'd1:    expByte = 8'(lba * 7 + 32'(addr));
      default: expByte = 8'(addr * 3 + 1);
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rdValid) rdValidCount++;

  // storage model: fills the buffer after a fill request, then acknowledges
  initial begin
    forever begin
      @(negedge clk);
      if (fillReq && !fillAck) begin
        logic [1:0]       k;
        logic [LBA_W-1:0] l;
        int               first;
        int               last;
        k = fillKind;
        l = fillLba;
        lastKind = k;
        lastLba = l;
        fillCount++;
        first = (k == 2'd2) ? 3 : 0;
        last  = (k == 2'd2) ? 512 : 128;
        repeat (2) @(negedge clk);
        for (int w = first; w < last; w++) begin
          fillWe   = 1'b1;
          fillAddr = 9'(w);
          fillData = {expByte(k, l, 4*w+3), expByte(k, l, 4*w+2),
                      expByte(k, l, 4*w+1), expByte(k, l, 4*w)};
          @(negedge clk);
        end
        fillWe  = 1'b0;
        fillAck = 1'b1;
        @(negedge clk);
        fillAck = 1'b0;
      end
    end
  end

  task automatic doCmd(input logic [7:0] code);
    @(negedge clk);
    cmdWrEn = 1'b1;
    cmdData = code;
    @(negedge clk);
    cmdWrEn = 1'b0;
  endtask

  task automatic doSecCnt(input logic [7:0] v);
    @(negedge clk);
    secCntWrEn = 1'b1;
    secCntData = v;
    @(negedge clk);
    secCntWrEn = 1'b0;
  endtask

  task automatic doWrite(input logic [1:0] size, input logic [31:0] v);
    @(negedge clk);
    dataWrEn   = 1'b1;
    dataSize   = size;
    dataWrData = v;
    @(negedge clk);
    dataWrEn = 1'b0;
  endtask

  task automatic doRead(input logic [1:0] size, output logic [31:0] v,
                        output logic sawIrq, output int lat);
    @(negedge clk);
    dataRdEn = 1'b1;
    dataSize = size;
    @(negedge clk);
    dataRdEn = 1'b0;
    lat = 1;
    while (!rdValid && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
    v = rdData;
    sawIrq = irq;
  endtask

  task automatic waitIrq(output int cyc);
    cyc = 0;
    while (!irq && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  function automatic logic [31:0] expWord(input logic [1:0] kind, input logic [31:0] lba,
                                          input int off, input int len);
    logic [31:0] r;
    r = '0;
    for (int b = 0; b < len; b++) r[8*b +: 8] = expByte(kind, lba, off + b);
    return r;
  endfunction

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic        sIrq;
    int          lat, cyc, irqCnt, badData, fc0, rv0;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", status, 8'h50);
    check("R1 error", errReg, 8'h01);
    check("R1 seccount", secCount, 8'h01);
    check("R1 req/irq", {fillReq, irq}, 2'b00);

    // R13 unknown command
    slotKind = 2'd1;
    doCmd(8'h55);
    check("R13 status", status, 8'h51);
    check("R13 error", errReg, 8'h05);
    check("R13 no irq", irq, 1'b0);

    // R3 mismatches
    slotKind = 2'd0;
    doCmd(8'hEC);
    check("R3 ec status", status, 8'h41);
    check("R3 ec error", errReg, 8'h04);
    check("R3 ec irq/req", {irq, fillReq}, 2'b10);
    slotKind = 2'd1;
    doCmd(8'hA1);
    check("R3 a1 status/irq", {status, 7'd0, irq}, {8'h41, 8'h01});
    doCmd(8'hA0);
    check("R3 a0 status/irq", {status, 7'd0, irq}, {8'h41, 8'h01});
    slotKind = 2'd2;
    doCmd(8'h21);
    check("R3 rd on pkt", {status, errReg, 7'd0, irq}, {8'h41, 8'h04, 8'h01});

    // R12 set features
    doCmd(8'hEF);
    check("R12 status", status, 8'h50);
    check("R12 irq", irq, 1'b1);

    // R2 identify on a disk slot
    slotKind = 2'd1;
    doCmd(8'hEC);
    check("R2 busy pending", {status, 7'd0, fillReq}, {8'h80, 8'h01});
    waitIrq(cyc);
    check("R2 kind", lastKind, 2'd0);
    check("R2 status", status, 8'h58);
    check("R2 error", errReg, 8'h00);

    // R11 identify reads, mixed sizes
    irqCnt = 0; badData = 0;
    doRead(2'd0, v, sIrq, lat);
    check("R11 byte0", v, expWord(2'd0, 0, 0, 1));
    doRead(2'd0, v, sIrq, lat);
    check("R11 byte1", v, expWord(2'd0, 0, 1, 1));
    doRead(2'd1, v, sIrq, lat);
    check("R11 half", v, expWord(2'd0, 0, 2, 2));
    for (int i = 1; i < 128; i++) begin
      doRead(2'd2, v, sIrq, lat);
      if (sIrq) irqCnt++;
      if (v !== expWord(2'd0, 0, 4*i, 4)) badData++;
      if (i == 126) check("R11 drq held", status, 8'h58);
    end
    check("R11 data", badData, 0);
    check("R11 no irq", irqCnt, 0);
    check("R11 drq clear", status, 8'h50);

    // R6 / R14 sector read command, strobes during the pending fill
    doSecCnt(8'd2);
    check("R6 seccount", secCount, 8'd2);
    lbaIn = 32'd5;
    rv0 = rdValidCount;
    doCmd(8'h20);
    @(negedge clk);
    dataRdEn = 1'b1; dataSize = 2'd2; cmdWrEn = 1'b1; cmdData = 8'hEF;
    secCntWrEn = 1'b1; secCntData = 8'd9;
    @(negedge clk);
    dataRdEn = 1'b0; cmdWrEn = 1'b0; secCntWrEn = 1'b0;
    check("R14 req held", fillReq, 1'b1);
    waitIrq(cyc);
    check("R6 kind/lba", {lastKind, lastLba}, {2'd1, 32'd5});
    check("R6 status", status, 8'h58);
    check("R14 no read served", rdValidCount - rv0, 0);
    check("R14 seccount kept", secCount, 8'd2);

    // R7 / R9 first sector by dwords
    irqCnt = 0; badData = 0;
    for (int i = 0; i < 128; i++) begin
      doRead(2'd2, v, sIrq, lat);
      if (v !== expWord(2'd1, 5, 4*i, 4)) badData++;
      if (lat != 1) badData++;
      if (sIrq) irqCnt++;
      if (i == 127) check("R9 irq at boundary", sIrq, 1'b1);
    end
    check("R7 data+latency", badData, 0);
    check("R9 one irq", irqCnt, 1);
    check("R9 drq kept", status, 8'h58);

    // R8 refill, second sector by halfwords
    fc0 = fillCount;
    doRead(2'd1, v, sIrq, lat);
    check("R8 refill lba", {fillCount - fc0, lastLba}, {32'd1, 32'd6});
    check("R8 data", v, expWord(2'd1, 6, 0, 2));
    check("R8 latency > 1", lat > 1, 1'b1);
    irqCnt = 0; badData = 0;
    for (int i = 1; i < 256; i++) begin
      doRead(2'd1, v, sIrq, lat);
      if (v !== expWord(2'd1, 6, 2*i, 2)) badData++;
      if (sIrq) irqCnt++;
    end
    check("R7 second sector", badData, 0);
    check("R9 final irq", irqCnt, 1);
    check("R9 final status", status, 8'h50);

    // R10 overrun
    fc0 = fillCount;
    doRead(2'd2, v, sIrq, lat);
    check("R10 data", v, 32'h0);
    check("R10 status", status, 8'h51);
    check("R10 latency/no fill", {lat, fillCount - fc0}, {32'd1, 32'd0});
    doRead(2'd2, v, sIrq, lat);
    check("R10 index unchanged", {v, status}, {32'h0, 8'h51});

    // R13 absent slot read
    slotKind = 2'd0;
    doRead(2'd2, v, sIrq, lat);
    check("R13 empty read", {v, 31'd0, rdValid}, {32'h0, 32'h1});

    // R4 packet command
    slotKind = 2'd2;
    fillLen = IDX_W'(2048);
    doCmd(8'hA0);
    check("R4 status", status, 8'h58);
    check("R4 seccount/irq/req", {secCount, irq, fillReq}, {8'd1, 2'b00});

    // R5 packet bytes
    doWrite(2'd2, 32'h44332211);
    doWrite(2'd2, 32'h88776655);
    doWrite(2'd1, 32'h0000AA99);
    doWrite(2'd0, 32'h000000BB);
    check("R5 no dispatch yet", fillReq, 1'b0);
    doWrite(2'd0, 32'h000000CC);
    check("R5 dispatch", {fillReq, fillKind}, {1'b1, 2'd2});
    waitIrq(cyc);
    check("R5 status", status, 8'h58);

    // R7 packet read, block 2048
    doRead(2'd2, v, sIrq, lat);
    check("R5 echo0", v, 32'h44332211);
    doRead(2'd2, v, sIrq, lat);
    check("R5 echo1", v, 32'h88776655);
    doRead(2'd2, v, sIrq, lat);
    check("R5 echo2", v, 32'hCCBBAA99);
    irqCnt = 0; badData = 0;
    for (int i = 3; i < 512; i++) begin
      doRead(2'd2, v, sIrq, lat);
      if (v !== expWord(2'd2, 0, 4*i, 4)) badData++;
      if (sIrq) irqCnt++;
    end
    check("R7 packet data", badData, 0);
    check("R9 packet irq", irqCnt, 1);
    check("R9 packet end", status, 8'h50);

    // R2 packet identify
    doCmd(8'hA1);
    waitIrq(cyc);
    check("R2 pkt ident", {lastKind, status, errReg}, {2'd0, 8'h58, 8'h00});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule